// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block sits on the receive path of an Ethernet controller. It watches a byte stream in which each frame is bracketed by start and end markers. It captures the first six bytes as the destination address and measures the frame length. From the destination address it also forms a six-bit multicast hash.

When the last byte of a frame arrives, the block decides whether the frame is kept or thrown away. The decision follows a fixed order of tests: the transmitter-off override first, then the length limits, then the address class, and finally whether the receive unit can take the frame.

The result is one pulse that carries three things together: the decision, a 16-bit status word that records how the frame was classified, and the measured length. Two saturating counters keep track of short frames and of frames lost because the receive unit was not ready. Downstream logic uses the pulse to commit the frame into a buffer or to discard it.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: After reset, `res_valid`, `res_accept`, `res_status`, `res_length` and both counters are zero.
- R2: The result appears as a pulse on `res_valid` that lasts exactly one cycle. It comes in the cycle after the clock edge that accepts the end-marked byte, and `res_length` then equals the number of bytes in the frame. A frame that ends before its sixth byte produces no pulse and changes no counter.
- R3: With `cfg_xmit_disable` high, every frame is dropped and neither counter moves.
- R4: A frame shorter than MIN_FRAME bytes (default 64) adds one to `short_err_count` when `cfg_discard_short` is high, and it is still classified by address. An accepted short frame sets status bit 7 (0x0080).
- R5: A frame longer than MAX_FRAME+4 bytes is dropped unless `cfg_long_ok` is high. A frame of exactly MAX_FRAME+4 bytes passes the length test.
- R6: The destination address is compared with `station_addr`. The first received byte is compared with bits [47:40], and so on down to the sixth byte against bits [7:0]. An exact match is accepted with status 0xA000, and this test takes priority over the broadcast and multicast tests.
- R7: An all-ones destination that does not match the station address is accepted with status 0xA002.
- R8: A destination whose first byte has bit 0 set (multicast), and which matches neither earlier test, is accepted with status 0xA002 only when `hash_table[idx]` is 1; otherwise it is dropped. The index idx is formed as follows. A reflected CRC-32 register (polynomial 0xEDB88320, preset to all ones, no final inversion) takes the six address bytes, each byte least significant bit first. idx is the low six bits of that register. Bits idx[5:3] therefore pick a byte of the table and idx[2:0] a bit within it.
- R9: A unicast frame that matches no earlier test is accepted with status 0xA004 when `cfg_promisc` is high. A multicast frame that misses the hash table is dropped even in promiscuous mode.
- R10: A unicast frame that matches no test while `cfg_promisc` is low is dropped without touching the resource counter.
- R11: A frame that passes filtering while `ru_ready` is low is dropped, and `resource_err_count` is incremented.
- R12: Every accepted result has 0xA in `res_status[15:12]`. Every dropped result reports `res_status` = 0x0000.
- R13: Both counters saturate at their all-ones value and return to zero on the clock edge where `cnt_clear` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte present on `in_data` |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_data | input | 8 | Received byte |
| station_addr | input | 48 | Own unicast address, first byte in [47:40] |
| hash_table | input | HASH_BITS | Multicast acceptance bits |
| cfg_xmit_disable | input | 1 | Drop every frame |
| cfg_discard_short | input | 1 | Count frames below MIN_FRAME |
| cfg_long_ok | input | 1 | Allow frames above MAX_FRAME+4 |
| cfg_promisc | input | 1 | Accept unmatched unicast frames |
| ru_ready | input | 1 | Receive unit can take a frame |
| cnt_clear | input | 1 | Synchronous clear of both counters |
| res_valid | output | 1 | One-cycle result strobe |
| res_accept | output | 1 | Frame is kept |
| res_status | output | 16 | Classification status word |
| res_length | output | LEN_W | Measured frame length in bytes |
| short_err_count | output | CNT_W | Short-frame counter |
| resource_err_count | output | CNT_W | Not-ready drop counter |

## Verification
The bench builds the filter with MAX_FRAME = 100 and CNT_W = 3; all other parameters keep their defaults. The lower maximum puts the long-frame limit at 104 bytes, so a frame of 105 bytes reaches the drop boundary after only a hundred cycles. The three-bit counters reach saturation within eight frames, so the wrap-free saturation and the clear are checked directly. Multicast acceptance is checked against hash indices that the bench computes itself, including a miss under promiscuous mode.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

    localparam int          ADDR_BYTES     = 6;
    localparam logic [31:0] CRC_POLY_REFL  = 32'hEDB88320;
    localparam logic [15:0] STATUS_BASE    = 16'hA000;
    localparam int          ST_GROUP_BIT   = 1;
    localparam int          ST_PROMISC_BIT = 2;
    localparam int          ST_SHORT_BIT   = 7;

    // One byte of reflected CRC-32, least significant bit first
    function automatic logic [31:0] crc_step(input logic [31:0] crc_in, input logic [7:0] b);
        logic [31:0] c;
        c = crc_in ^ {24'd0, b};
        for (int i = 0; i < 8; i++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/rxaf_crc_hash.sv
module rxaf_crc_hash
    import rxaf_pkg::*;
#(
    parameter int HASH_BITS = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         restart,
    input  logic                         take,
    input  logic [7:0]                   data,
    output logic [$clog2(HASH_BITS)-1:0] idx_next
);
    localparam int IDX_W = $clog2(HASH_BITS);

    typedef struct packed {
        logic [31:0] crc;
    } crc_st_t;

    crc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.crc = crc_step(restart ? 32'hFFFF_FFFF : st_q.crc, data);
        end
        idx_next = st_d.crc[IDX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{crc: 32'hFFFF_FFFF};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rxaf_sat_cnt.sv
module rxaf_sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                      cnt_d = '0;
        else if (inc && cnt_q != TOP) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/rxaf_classify.sv
module rxaf_classify
    import rxaf_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int MIN_FRAME = 64,
    parameter int MAX_FRAME = 1514,
    parameter int HASH_BITS = 64
) (
    input  logic [47:0]                  dst,
    input  logic [LEN_W-1:0]             frame_len,
    input  logic [47:0]                  station_addr,
    input  logic [HASH_BITS-1:0]         hash_table,
    input  logic [$clog2(HASH_BITS)-1:0] hash_idx,
    input  logic                         cfg_xmit_off,
    input  logic                         cfg_count_short,
    input  logic                         cfg_long_ok,
    input  logic                         cfg_promisc,
    input  logic                         ru_ready,
    output logic                         accept,
    output logic [15:0]                  status,
    output logic                         short_hit,
    output logic                         res_hit
);
    localparam logic [LEN_W-1:0] SHORT_LIM = LEN_W'(MIN_FRAME);
    localparam logic [LEN_W-1:0] LONG_LIM  = LEN_W'(MAX_FRAME + 4);

    logic        is_short, is_long, is_station, is_bcast, is_group, hash_hit, passed;
    logic [15:0] class_bits;

    always_comb begin
        is_short   = frame_len < SHORT_LIM;
        is_long    = frame_len > LONG_LIM;
        is_station = (dst == station_addr);
        is_bcast   = &dst;
        is_group   = dst[40];
        hash_hit   = hash_table[hash_idx];
        passed     = 1'b0;
        class_bits = '0;
        short_hit  = 1'b0;

        // fixed priority: override, length, address class
        if (!cfg_xmit_off) begin
            short_hit = is_short && cfg_count_short;
            if (!is_long || cfg_long_ok) begin
                if (is_station) begin
                    passed = 1'b1;
                end else if (is_bcast) begin
                    passed                   = 1'b1;
                    class_bits[ST_GROUP_BIT] = 1'b1;
                end else if (is_group) begin
                    passed                   = hash_hit;
                    class_bits[ST_GROUP_BIT] = 1'b1;
                end else if (cfg_promisc) begin
                    passed                     = 1'b1;
                    class_bits[ST_PROMISC_BIT] = 1'b1;
                end
            end
        end
        if (is_short) class_bits[ST_SHORT_BIT] = 1'b1;

        res_hit = passed && !ru_ready;
        accept  = passed && ru_ready;
        status  = accept ? (STATUS_BASE | class_bits) : 16'h0000;
    end
endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
    import rxaf_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int MIN_FRAME = 64,
    parameter int MAX_FRAME = 1514,
    parameter int CNT_W     = 32,
    parameter int HASH_BITS = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_sof,
    input  logic                 in_eof,
    input  logic [7:0]           in_data,
    input  logic [47:0]          station_addr,
    input  logic [HASH_BITS-1:0] hash_table,
    input  logic                 cfg_xmit_disable,
    input  logic                 cfg_discard_short,
    input  logic                 cfg_long_ok,
    input  logic                 cfg_promisc,
    input  logic                 ru_ready,
    input  logic                 cnt_clear,
    output logic                 res_valid,
    output logic                 res_accept,
    output logic [15:0]          res_status,
    output logic [LEN_W-1:0]     res_length,
    output logic [CNT_W-1:0]     short_err_count,
    output logic [CNT_W-1:0]     resource_err_count
);
    localparam int               HASH_IDX_W = $clog2(HASH_BITS);
    localparam logic [LEN_W-1:0] LEN_TOP    = '1;

    typedef struct packed {
        logic             active;
        logic [LEN_W-1:0] len;
        logic [47:0]      dst;
    } frm_t;

    typedef struct packed {
        logic             valid;
        logic             accept;
        logic [15:0]      status;
        logic [LEN_W-1:0] len;
    } res_t;

    frm_t frm_d, frm_q;
    res_t res_d, res_q;

    logic                  byte_take, addr_take, frame_done;
    logic [LEN_W-1:0]      pos;
    logic [HASH_IDX_W-1:0] hash_idx;
    logic                  cls_accept, cls_short, cls_res;
    logic [15:0]           cls_status;

    // frame tracking: length, destination capture, end detection
    always_comb begin
        frm_d     = frm_q;
        byte_take = in_valid && (in_sof || frm_q.active);
        pos       = in_sof ? '0 : frm_q.len;
        addr_take = byte_take && (pos < LEN_W'(ADDR_BYTES));
        if (byte_take) begin
            frm_d.active = !in_eof;
            if (in_sof)                   frm_d.len = LEN_W'(1);
            else if (frm_q.len != LEN_TOP) frm_d.len = frm_q.len + 1'b1;
            for (int k = 0; k < ADDR_BYTES; k++) begin
                if (addr_take && pos == LEN_W'(k)) begin
                    frm_d.dst[8*(ADDR_BYTES-1-k) +: 8] = in_data;
                end
            end
        end
        frame_done = byte_take && in_eof && (frm_d.len >= LEN_W'(ADDR_BYTES));
    end

    rxaf_crc_hash #(.HASH_BITS(HASH_BITS)) i_hash (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (in_sof),
        .take     (addr_take),
        .data     (in_data),
        .idx_next (hash_idx)
    );

    rxaf_classify #(
        .LEN_W     (LEN_W),
        .MIN_FRAME (MIN_FRAME),
        .MAX_FRAME (MAX_FRAME),
        .HASH_BITS (HASH_BITS)
    ) i_classify (
        .dst             (frm_d.dst),
        .frame_len       (frm_d.len),
        .station_addr    (station_addr),
        .hash_table      (hash_table),
        .hash_idx        (hash_idx),
        .cfg_xmit_off    (cfg_xmit_disable),
        .cfg_count_short (cfg_discard_short),
        .cfg_long_ok     (cfg_long_ok),
        .cfg_promisc     (cfg_promisc),
        .ru_ready        (ru_ready),
        .accept          (cls_accept),
        .status          (cls_status),
        .short_hit       (cls_short),
        .res_hit         (cls_res)
    );

    // result staging
    always_comb begin
        res_d       = res_q;
        res_d.valid = 1'b0;
        if (frame_done) begin
            res_d.valid  = 1'b1;
            res_d.accept = cls_accept;
            res_d.status = cls_status;
            res_d.len    = frm_d.len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q <= '0;
            res_q <= '0;
        end else begin
            frm_q <= frm_d;
            res_q <= res_d;
        end
    end

    rxaf_sat_cnt #(.W(CNT_W)) i_short_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clear),
        .inc   (frame_done && cls_short),
        .count (short_err_count)
    );

    rxaf_sat_cnt #(.W(CNT_W)) i_res_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clear),
        .inc   (frame_done && cls_res),
        .count (resource_err_count)
    );

    assign res_valid  = res_q.valid;
    assign res_accept = res_q.accept;
    assign res_status = res_q.status;
    assign res_length = res_q.len;
endmodule

// File: rtl/rxaf_checker.sv
module rxaf_checker #(
    parameter int LEN_W     = 16,
    parameter int CNT_W     = 32,
    parameter int MAX_FRAME = 1514
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_eof,
    input logic             cfg_xmit_disable,
    input logic             cfg_long_ok,
    input logic             cnt_clear,
    input logic             res_valid,
    input logic             res_accept,
    input logic [15:0]      res_status,
    input logic [LEN_W-1:0] res_length,
    input logic [CNT_W-1:0] short_err_count,
    input logic [CNT_W-1:0] resource_err_count
);
    localparam logic [LEN_W-1:0] LONG_LIM = LEN_W'(MAX_FRAME + 4);

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_after_eof_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(in_valid && in_eof));

    assert_xmit_off_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(cfg_xmit_disable)) |-> !res_accept);

    assert_long_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !$past(cfg_long_ok) && res_length > LONG_LIM) |-> !res_accept);

    assert_class_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !(res_status[1] && res_status[2]));

    assert_resource_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_clear) && resource_err_count != $past(resource_err_count))
            |-> (res_valid && !res_accept));

    assert_accept_base_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_accept) |-> res_status[15:12] == 4'hA);

    assert_drop_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_accept) |-> res_status == 16'h0000);

    assert_no_decrease_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clear |=> (short_err_count >= $past(short_err_count)));
endmodule

bind eth_rx_addr_filter rxaf_checker #(
    .LEN_W     (LEN_W),
    .CNT_W     (CNT_W),
    .MAX_FRAME (MAX_FRAME)
) i_rxaf_checker (
    .clk                (clk),
    .rst_n              (rst_n),
    .in_valid           (in_valid),
    .in_eof             (in_eof),
    .cfg_xmit_disable   (cfg_xmit_disable),
    .cfg_long_ok        (cfg_long_ok),
    .cnt_clear          (cnt_clear),
    .res_valid          (res_valid),
    .res_accept         (res_accept),
    .res_status         (res_status),
    .res_length         (res_length),
    .short_err_count    (short_err_count),
    .resource_err_count (resource_err_count)
);

// File: tb/test_eth_rx_addr_filter.sv
module test_eth_rx_addr_filter;
    localparam int LEN_W   = 16;
    localparam int CNT_W   = 3;
    localparam int MAXF    = 100;
    localparam int CNT_TOP = (1 << CNT_W) - 1;

    localparam logic [47:0] SA = 48'h02_11_22_33_44_55;
    localparam logic [47:0] OA = 48'h04_AA_BB_CC_DD_EE;
    localparam logic [47:0] BA = 48'hFF_FF_FF_FF_FF_FF;
    localparam logic [47:0] MA = 48'h01_00_5E_00_00_07;

    typedef struct packed {
        logic [47:0] dst;
        logic [15:0] len;
        logic [4:0]  cfg;   // xmit_off, discard_short, long_ok, promisc, ru_ready
        logic        acc;
        logic [15:0] st;
        logic        sinc;
        logic        rinc;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{SA, 16'd64,  5'b00001, 1'b1, 16'hA000, 1'b0, 1'b0}, // R6 station
        '{SA, 16'd60,  5'b00001, 1'b1, 16'hA080, 1'b0, 1'b0}, // R4 short, not counted
        '{SA, 16'd60,  5'b01001, 1'b1, 16'hA080, 1'b1, 1'b0}, // R4 short counted, still accepted
        '{BA, 16'd70,  5'b00001, 1'b1, 16'hA002, 1'b0, 1'b0}, // R7 broadcast
        '{OA, 16'd70,  5'b00001, 1'b0, 16'h0000, 1'b0, 1'b0}, // R10 no match
        '{OA, 16'd70,  5'b00011, 1'b1, 16'hA004, 1'b0, 1'b0}, // R9 promiscuous
        '{SA, 16'd105, 5'b00001, 1'b0, 16'h0000, 1'b0, 1'b0}, // R5 long dropped
        '{SA, 16'd105, 5'b00101, 1'b1, 16'hA000, 1'b0, 1'b0}, // R5 long allowed
        '{SA, 16'd104, 5'b00001, 1'b1, 16'hA000, 1'b0, 1'b0}, // R5 boundary
        '{SA, 16'd70,  5'b10001, 1'b0, 16'h0000, 1'b0, 1'b0}, // R3 override
        '{SA, 16'd60,  5'b11001, 1'b0, 16'h0000, 1'b0, 1'b0}, // R3 no short count
        '{SA, 16'd70,  5'b00000, 1'b0, 16'h0000, 1'b0, 1'b1}, // R11 not ready
        '{BA, 16'd60,  5'b01000, 1'b0, 16'h0000, 1'b1, 1'b1}, // R11 and R4 together
        '{OA, 16'd70,  5'b00000, 1'b0, 16'h0000, 1'b0, 1'b0}  // R10 filtered before R11
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]           in_data = '0;
    logic [47:0]          station_addr = SA;
    logic [63:0]          hash_table = '0;
    logic                 cfg_xmit_disable = 1'b0, cfg_discard_short = 1'b0;
    logic                 cfg_long_ok = 1'b0, cfg_promisc = 1'b0, ru_ready = 1'b1;
    logic                 cnt_clear = 1'b0;
    logic                 res_valid, res_accept;
    logic [15:0]          res_status;
    logic [LEN_W-1:0]     res_length;
    logic [CNT_W-1:0]     short_err_count, resource_err_count;

    int checks = 0;
    int errors = 0;
    int exp_s  = 0;
    int exp_r  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    eth_rx_addr_filter #(
        .LEN_W     (LEN_W),
        .MAX_FRAME (MAXF),
        .CNT_W     (CNT_W)
    ) i_eth_rx_addr_filter (
        .clk                (clk),
        .rst_n              (rst_n),
        .in_valid           (in_valid),
        .in_sof             (in_sof),
        .in_eof             (in_eof),
        .in_data            (in_data),
        .station_addr       (station_addr),
        .hash_table         (hash_table),
        .cfg_xmit_disable   (cfg_xmit_disable),
        .cfg_discard_short  (cfg_discard_short),
        .cfg_long_ok        (cfg_long_ok),
        .cfg_promisc        (cfg_promisc),
        .ru_ready           (ru_ready),
        .cnt_clear          (cnt_clear),
        .res_valid          (res_valid),
        .res_accept         (res_accept),
        .res_status         (res_status),
        .res_length         (res_length),
        .short_err_count    (short_err_count),
        .resource_err_count (resource_err_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] hash_of(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb = c[0] ^ a[47 - 8*i - 7 + b];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return c[5:0];
    endfunction

    // drives n bytes; returns at the negedge after the end byte's clock edge
    task automatic send_frame(input logic [47:0] d, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_eof   = (i == n - 1);
            in_data  = (i < 6) ? d[47 - 8*i -: 8] : 8'(i);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
    endtask

    task automatic bump(input bit s, input bit r);
        if (s && exp_s < CNT_TOP) exp_s++;
        if (r && exp_r < CNT_TOP) exp_r++;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [5:0] idx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 res_valid", 32'(res_valid), 0);
        chk("R1 res_status", 32'(res_status), 0);
        chk("R1 res_length", 32'(res_length), 0);
        chk("R1 short count", 32'(short_err_count), 0);
        chk("R1 resource count", 32'(resource_err_count), 0);

        for (int i = 0; i < NV; i++) begin
            {cfg_xmit_disable, cfg_discard_short, cfg_long_ok, cfg_promisc, ru_ready} = VECS[i].cfg;
            send_frame(VECS[i].dst, int'(VECS[i].len));
            bump(VECS[i].sinc, VECS[i].rinc);
            chk($sformatf("R2 valid vec %0d", i), 32'(res_valid), 1);
            chk($sformatf("R2 length vec %0d", i), 32'(res_length), 32'(VECS[i].len));
            chk($sformatf("R12 accept vec %0d", i), 32'(res_accept), 32'(VECS[i].acc));
            chk($sformatf("R12 status vec %0d", i), 32'(res_status), 32'(VECS[i].st));
            chk($sformatf("R4 short count vec %0d", i), 32'(short_err_count), 32'(exp_s));
            chk($sformatf("R11 resource count vec %0d", i), 32'(resource_err_count), 32'(exp_r));
            @(negedge clk);
            chk($sformatf("R2 one-cycle pulse vec %0d", i), 32'(res_valid), 0);
        end

        // R8 multicast hash hit and miss
        {cfg_xmit_disable, cfg_discard_short, cfg_long_ok, cfg_promisc, ru_ready} = 5'b00001;
        idx = hash_of(MA);
        hash_table = 64'd1 << idx;
        send_frame(MA, 70);
        chk("R8 hash hit accept", 32'(res_accept), 1);
        chk("R8 hash hit status", 32'(res_status), 32'hA002);
        send_frame(MA, 60);
        chk("R4 short multicast status", 32'(res_status), 32'hA082);
        hash_table = ~(64'd1 << idx);
        send_frame(MA, 70);
        chk("R8 hash miss drop", 32'(res_accept), 0);
        cfg_promisc = 1'b1;
        send_frame(MA, 70);
        chk("R9 hash miss under promiscuous", 32'(res_accept), 0);
        cfg_promisc = 1'b0;

        // R6 station match beats broadcast
        station_addr = BA;
        send_frame(BA, 70);
        chk("R6 station over broadcast", 32'(res_status), 32'hA000);
        station_addr = SA;

        // R2 runt below six bytes: no pulse, no counting
        cfg_discard_short = 1'b1;
        send_frame(SA, 5);
        chk("R2 runt no pulse", 32'(res_valid), 0);
        chk("R2 runt short count", 32'(short_err_count), 32'(exp_s));

        // R13 saturation and clear
        for (int i = 0; i < CNT_TOP + 2; i++) begin
            send_frame(SA, 60);
            bump(1'b1, 1'b0);
        end
        chk("R13 short saturates", 32'(short_err_count), 32'(CNT_TOP));
        cfg_discard_short = 1'b0;
        ru_ready = 1'b0;
        for (int i = 0; i < CNT_TOP + 2; i++) begin
            send_frame(SA, 64);
            bump(1'b0, 1'b1);
        end
        chk("R13 resource saturates", 32'(resource_err_count), 32'(CNT_TOP));
        ru_ready = 1'b1;
        @(negedge clk);
        cnt_clear = 1'b1;
        @(negedge clk);
        cnt_clear = 1'b0;
        chk("R13 short cleared", 32'(short_err_count), 0);
        chk("R13 resource cleared", 32'(resource_err_count), 0);

        finish_run();
    end
endmodule